// File: doc/BRIEF.md
# Maskable Event Interrupt Controller with Clear-on-Read

This block gathers eight one-cycle event pulses into sticky flags and raises a single interrupt pin while any flag is set whose mask bit is also set. A processor reaches the block through a plain register port. One 16-bit word holds the eight mask bits in its upper byte and the eight flags in its lower byte. A separate control word carries the pin polarity.

Reading the combined word returns its contents and clears every flag in the same step. An event that arrives during that read is kept, so no event is lost. The pin is active-low by default and can be switched to active-high.

Top module: `irq_event_ctrl`

## Requirements
- R1: A high bit on `evt_i` sets the matching flag (word 0x1B bit i, for event i) at the next clock edge, whether or not its mask bit is set.
- R2: A flag stays set until word 0x1B is read. Writes, reads of other addresses and idle cycles do not clear it.
- R3: A read of address 0x1B returns {mask[7:0], flags[7:0]} on `reg_rdata` one cycle after `reg_rd`. The value returned is the one held before the read. The same edge clears every flag.
- R4: If an event arrives in the same cycle as a read of 0x1B, its flag is set after that edge.
- R5: A write to 0x1B loads the mask from `reg_wdata[15:8]`. Bits 7:0 of the write are ignored, so the flags are unchanged.
- R6: The interrupt is active when (flags AND mask) is nonzero. Otherwise it is inactive.
- R7: Bit 9 of address 0x1F sets the pin polarity: 0 means active-low and 1 means active-high. A read of 0x1F returns only bit 9, with all other bits 0, and does not clear the flags.
- R8: After reset the mask, the flags and the polarity bit are all 0, and `irq_pin` is high.
- R9: A read of any address other than 0x1B and 0x1F returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_i | input | 8 | One-cycle event pulses |
| reg_addr | input | 5 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 16 | Write data |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | 16 | Read data, registered |
| irq_pin | output | 1 | Interrupt output, polarity programmable |

## Verification
The assertions check four properties on every cycle: events reach their flags, flags stay set outside a clearing read, a clearing read empties the flags, and read data and mask writes land one cycle later. Polarity changes, the interaction between masks and the pin level, reads of the control word and of unused addresses, and an event that collides with a clearing read are shown only by the bench. The bench runs directed and random sequences against its own model of the registers.

// File: rtl/irq_event_ctrl.sv
module irq_event_ctrl #(
  parameter int NUM_EVT  = 8,
  parameter int ADDR_W   = 5,
  parameter int DATA_W   = 16,
  parameter logic [ADDR_W-1:0] IRQ_ADDR  = 5'h1B,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 5'h1F,
  parameter int POL_BIT  = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              reg_rd,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq_pin
);
  localparam int PAD_W = DATA_W - 2*NUM_EVT;

  logic [NUM_EVT-1:0] mask_q, flag_q;
  logic               pol_q;

  wire hit_irq  = reg_addr == IRQ_ADDR;
  wire hit_ctrl = reg_addr == CTRL_ADDR;
  wire clr_rd   = reg_rd && hit_irq;
  wire [DATA_W-1:0] irq_word  = {{PAD_W{1'b0}}, mask_q, flag_q};
  wire [DATA_W-1:0] ctrl_word = DATA_W'(pol_q) << POL_BIT;
  wire pending = |(flag_q & mask_q);

  assign irq_pin = pol_q ? pending : !pending;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q    <= '0;
      flag_q    <= '0;
      pol_q     <= 1'b0;
      reg_rdata <= '0;
    end else begin
      flag_q <= (clr_rd ? '0 : flag_q) | evt_i;
      if (reg_wr && hit_irq)  mask_q <= reg_wdata[2*NUM_EVT-1:NUM_EVT];
      if (reg_wr && hit_ctrl) pol_q  <= reg_wdata[POL_BIT];
      if (reg_rd)
        reg_rdata <= hit_irq ? irq_word : hit_ctrl ? ctrl_word : '0;
    end
  end

  // R1
  evt_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_i) |=> ((flag_q & $past(evt_i)) == $past(evt_i)));

  // R2
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_rd && reg_addr == IRQ_ADDR) |=> ((flag_q & $past(flag_q)) == $past(flag_q)));

  // R3
  clear_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == IRQ_ADDR && evt_i == '0) |=> (flag_q == '0));

  // R3
  read_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == IRQ_ADDR) |=> (reg_rdata[2*NUM_EVT-1:0] == $past({mask_q, flag_q})));

  // R5
  mask_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == IRQ_ADDR) |=> (mask_q == $past(reg_wdata[2*NUM_EVT-1:NUM_EVT])));
endmodule

// File: tb/irq_event_ctrl_bench.sv
module irq_event_ctrl_bench;
  logic        clk = 0, rst_n = 0;
  logic [7:0]  evt_i = 0;
  logic [4:0]  reg_addr = 0;
  logic        reg_wr = 0, reg_rd = 0;
  logic [15:0] reg_wdata = 0;
  logic [15:0] reg_rdata;
  logic        irq_pin;
  int errors = 0, checks = 0;
  logic [7:0] m_mask = 0, m_flag = 0;
  logic       m_pol = 0;

  always #2.5 clk = ~clk;

  irq_event_ctrl u_irq_event_ctrl (.clk(clk), .rst_n(rst_n), .evt_i(evt_i),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rd(reg_rd), .reg_rdata(reg_rdata), .irq_pin(irq_pin));

  function automatic logic exp_pin(logic [7:0] mk, logic [7:0] fl, logic pl);
    return pl ? (|(mk & fl)) : !(|(mk & fl));
  endfunction

  function automatic logic [15:0] exp_read(logic [4:0] a);
    if (a == 5'h1B) return {m_mask, m_flag};
    if (a == 5'h1F) return 16'(m_pol) << 9;
    return 16'h0;
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(logic [7:0] ev, logic [4:0] a, logic wr, logic [15:0] wd,
                      logic rd, string req);
    logic [15:0] rexp;
    @(negedge clk);
    evt_i = ev; reg_addr = a; reg_wr = wr; reg_wdata = wd; reg_rd = rd;
    rexp = exp_read(a);
    @(posedge clk);
    #1;
    m_flag = ((rd && a == 5'h1B) ? 8'h00 : m_flag) | ev;
    if (wr && a == 5'h1B) m_mask = wd[15:8];
    if (wr && a == 5'h1F) m_pol = wd[9];
    @(negedge clk);
    evt_i = 0; reg_wr = 0; reg_rd = 0;
    if (rd) check(req, reg_rdata, rexp);
    check({req, " R6 pin"}, {15'h0, irq_pin}, {15'h0, exp_pin(m_mask, m_flag, m_pol)});
  endtask

  initial begin
    #200000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int seed;
    seed = 32'h5eed;
    void'($urandom(seed));
    #1;
    check("R8 pin at reset", {15'h0, irq_pin}, 16'h1);
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    step(0, 5'h1B, 0, 0, 1, "R8 reset word");
    step(0, 5'h1F, 0, 0, 1, "R8 reset polarity");
    step(8'h05, 5'h00, 0, 0, 0, "R1 event while masked");
    step(0, 5'h1B, 1, 16'h0400, 0, "R5 enable bit2 flags kept");
    step(0, 5'h1B, 1, 16'h04FF, 0, "R5 low byte ignored");
    step(0, 5'h03, 0, 0, 1, "R9 unused address");
    step(0, 5'h1F, 0, 0, 1, "R2 control read keeps flags");
    step(0, 5'h1F, 1, 16'hFFFF, 0, "R7 set active high");
    step(0, 5'h1F, 0, 0, 1, "R7 control readback");
    step(0, 5'h1B, 0, 0, 1, "R3 read returns old flags");
    step(0, 5'h1B, 0, 0, 1, "R3 flags cleared");
    step(8'h80, 5'h1B, 0, 0, 1, "R4 event during clear");
    step(0, 5'h1B, 0, 0, 1, "R4 event kept");
    step(0, 5'h1F, 1, 16'h0000, 0, "R7 back to active low");
    for (int i = 0; i < 400; i++) begin
      logic [4:0] a;
      int sel;
      sel = $urandom_range(0, 9);
      a = sel < 5 ? 5'h1B : sel < 8 ? 5'h1F : 5'($urandom_range(0, 31));
      step(($urandom_range(0, 3) == 0) ? 8'($urandom) : 8'h00, a,
           $urandom_range(0, 3) == 0, 16'($urandom), $urandom_range(0, 1) == 1,
           "R1 R2 R3 R5 R7 R9 random");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule